// File: doc/BRIEF.md
# Sample Frame Timer with Advanced Converter Load

This block produces the per-sample timing events of a codec serial port. It counts ticks of the internal master clock, which arrive as a one-cycle enable on the system clock, and divides them into sampling intervals of a fixed length. It raises an output frame sync once per interval, at the point where fresh ADC data is ready. The pulse lasts one serial clock period and ends on the serial clock strobe.

In each interval it also issues a single-cycle strobe that tells the DAC path to load its next sample. By default the strobe comes one serial clock period before the frame sync rises. A 5-bit advance value can pull it earlier in coarse steps. The advance value is captured only while the DAC is switched off. A captured value takes effect at the start of the next interval, so no interval ever sees two loads or none.

Top module: `sample_frame_timer`

## Requirements
- R1: While `rst_n` is low, `fs_out` and `dac_ld` are low and the captured advance value is zero. After release, counting starts from tick zero.
- R2: After reset release, `fs_out` first rises on the clock edge that consumes the 280th `tick_en` tick.
- R3: Once running, `fs_out` rises exactly once every 2048 `tick_en` ticks.
- R4: `fs_out` stays high until the first clock edge after its rise at which both `sclk_stb` and `tick_en` are high. It then falls. When the strobe arrives every 8 ticks in phase with the frame, the pulse is 8 ticks wide.
- R5: `dac_ld` is high for one clock cycle at a time. It pulses exactly once between two consecutive rises of `fs_out`.
- R6: When the advance value in use is 0, `dac_ld` rises 8 ticks (one serial clock period) before `fs_out` rises.
- R7: Each unit of advance moves the load 8 ticks earlier. For an advance of A, the load comes 8 + 8·A ticks before the frame sync, so A = 31 gives 256 ticks.
- R8: `adv_in` is captured only on clock edges where `dac_on` is low. While `dac_on` is high, changes on `adv_in` do not move the load.
- R9: A newly captured advance value applies only from the next interval start. An interval start is the tick that wraps the count from 2047 to 0. A change made within an interval leaves that interval's load where it was.
- R10: All timing is counted in `tick_en` ticks. Clock cycles with `tick_en` low advance nothing, so with one tick every 3 clocks the frame period is 6144 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle tick of the internal master clock |
| sclk_stb | input | 1 | Serial clock period strobe, honoured only with `tick_en` |
| dac_on | input | 1 | DAC enable; advance capture is frozen while high |
| adv_in | input | 5 | Load advance, in steps of 8 ticks |
| fs_out | output | 1 | Output frame sync, one serial period wide |
| dac_ld | output | 1 | DAC load strobe, one clock wide |

## Verification
The bench targets the off-by-one points of the first frame and of the load offset. A counter that starts at one, or that compares after its update, puts the first frame at 279 or 281 ticks and the default load at 7 or 9 ticks ahead. The largest advance of 31 is measured so that a truncated product or a dropped bit in the step multiply shows up as a wrong offset. Advance changes are made twice: while the DAC is on, where a design without the freeze moves the load, and inside a running interval, where a design that reads the value directly shifts that interval's load. A slowed tick pattern catches logic that counts clocks instead of ticks, because the frame period no longer stretches by three.

// File: rtl/sft_pkg.sv
package sft_pkg;

   // True when v is a non-zero power of two
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Largest load offset in ticks for a given advance width
   function automatic int unsigned max_offset(input int unsigned sclk_per,
                                              input int unsigned step,
                                              input int unsigned adv_w);
      return sclk_per + step * ((1 << adv_w) - 1);
   endfunction

endpackage

// File: rtl/sft_interval_ctr.sv
module sft_interval_ctr #(
   parameter int INTERVAL = 2048,
   localparam int CW = $clog2(INTERVAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   output logic [CW-1:0] cnt,
   output logic          wrap
);

   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   assign wrap = tick_en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (wrap)    cnt <= '0;
      else if (tick_en) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/sft_fsync_gen.sv
module sft_fsync_gen #(
   parameter int CW     = 11,
   parameter int FS_IDX = 279
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          sclk_stb,
   input  logic [CW-1:0] cnt,
   output logic          fs
);

   localparam logic [CW-1:0] FS_C = CW'(FS_IDX);

   logic hit;
   assign hit = tick_en && (cnt == FS_C);

   // rise has priority over the ending strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fs <= 1'b0;
      else if (hit)                        fs <= 1'b1;
      else if (fs && tick_en && sclk_stb)  fs <= 1'b0;
   end

endmodule

// File: rtl/sft_dac_load.sv
module sft_dac_load #(
   parameter int ADV_W    = 5,
   parameter int INTERVAL = 2048,
   parameter int FS_IDX   = 279,
   parameter int SCLK_PER = 8,
   parameter int STEP     = 8,
   localparam int CW      = $clog2(INTERVAL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wrap,
   input  logic             dac_on,
   input  logic [ADV_W-1:0] adv_in,
   input  logic [CW-1:0]    cnt,
   output logic [ADV_W-1:0] adv_held,
   output logic             dac_ld
);

   localparam logic [CW-1:0] FS_C   = CW'(FS_IDX);
   localparam logic [CW-1:0] SCLK_C = CW'(SCLK_PER);
   localparam logic [CW-1:0] STEP_C = CW'(STEP);

   logic [ADV_W-1:0] adv_eff;
   logic [CW-1:0]    off;
   logic [CW-1:0]    ld_pos;

   // capture stage: frozen while the converter runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       adv_held <= '0;
      else if (!dac_on) adv_held <= adv_in;
   end

   // apply stage: one value per interval
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    adv_eff <= '0;
      else if (wrap) adv_eff <= adv_held;
   end

   assign off = SCLK_C + CW'(adv_eff) * STEP_C;

   generate
      if (sft_pkg::is_pow2(INTERVAL)) begin : g_mask_wrap
         assign ld_pos = FS_C - off;
      end else begin : g_add_wrap
         localparam logic [CW:0] IV_C = (CW+1)'(INTERVAL);
         logic [CW:0] diff;
         logic [CW:0] fixed;
         assign diff   = {1'b0, FS_C} - {1'b0, off};
         assign fixed  = diff[CW] ? (diff + IV_C) : diff;
         assign ld_pos = fixed[CW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_ld <= 1'b0;
      else        dac_ld <= tick_en && (cnt == ld_pos);
   end

endmodule

// File: rtl/sample_frame_timer.sv
module sample_frame_timer #(
   parameter int ADV_W    = 5,
   parameter int INTERVAL = 2048,
   parameter int FIRST_FS = 280,
   parameter int SCLK_PER = 8,
   parameter int STEP     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             sclk_stb,
   input  logic             dac_on,
   input  logic [ADV_W-1:0] adv_in,
   output logic             fs_out,
   output logic             dac_ld
);

   localparam int CW     = $clog2(INTERVAL);
   localparam int FS_IDX = FIRST_FS - 1;

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("INTERVAL must be at least 2");
      end
      if (FIRST_FS < 1 || FIRST_FS > INTERVAL) begin : g_bad_first
         $error("FIRST_FS must lie within one interval");
      end
      if (sft_pkg::max_offset(SCLK_PER, STEP, ADV_W) >= INTERVAL) begin : g_bad_offset
         $error("largest load offset must be shorter than INTERVAL");
      end
   endgenerate

   logic [CW-1:0]    cnt;
   logic             wrap;
   logic [ADV_W-1:0] adv_held;

   sft_interval_ctr #(.INTERVAL(INTERVAL)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cnt     (cnt),
      .wrap    (wrap)
   );

   sft_fsync_gen #(.CW(CW), .FS_IDX(FS_IDX)) u_fs (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .sclk_stb (sclk_stb),
      .cnt      (cnt),
      .fs       (fs_out)
   );

   sft_dac_load #(
      .ADV_W    (ADV_W),
      .INTERVAL (INTERVAL),
      .FS_IDX   (FS_IDX),
      .SCLK_PER (SCLK_PER),
      .STEP     (STEP)
   ) u_ld (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .wrap     (wrap),
      .dac_on   (dac_on),
      .adv_in   (adv_in),
      .cnt      (cnt),
      .adv_held (adv_held),
      .dac_ld   (dac_ld)
   );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
   parameter int ADV_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             sclk_stb,
   input logic             dac_on,
   input logic             fs_out,
   input logic             dac_ld,
   input logic [ADV_W-1:0] adv_held
);

   // R5: load strobe never lasts two cycles
   p_ld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dac_ld |=> !dac_ld);

   // R10: frame sync only rises on a consumed tick
   p_fs_rise_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_out) |-> $past(tick_en));

   // R4: frame sync only falls on an honoured serial strobe
   p_fs_fall_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fs_out) |-> $past(sclk_stb && tick_en));

   // R8: captured advance frozen while the converter is on
   p_adv_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dac_on |=> $stable(adv_held));

   // R1: outputs quiet right after reset release
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!fs_out && !dac_ld));

endmodule

bind sample_frame_timer sft_checker #(.ADV_W(ADV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .sclk_stb (sclk_stb),
   .dac_on   (dac_on),
   .fs_out   (fs_out),
   .dac_ld   (dac_ld),
   .adv_held (adv_held)
);

// File: tb/sample_frame_timer_tb.sv
module sample_frame_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       sclk_stb = 1'b0;
   logic       dac_on = 1'b0;
   logic [4:0] adv_in = '0;
   logic       fs_out;
   logic       dac_ld;

   int n_run = 0;
   int n_fail = 0;
   int en_div = 1;
   int cyc = 0;
   int tick_cnt = 0;
   int fs_n = 0, fs_stamp = 0, fs_cyc = 0;
   int ld_n = 0, ld_stamp = 0;
   logic fs_prev = 1'b0, ld_prev = 1'b0;

   always #10 clk = ~clk;

   sample_frame_timer u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .sclk_stb (sclk_stb),
      .dac_on   (dac_on),
      .adv_in   (adv_in),
      .fs_out   (fs_out),
      .dac_ld   (dac_ld)
   );

   // tick index bookkeeping of the bench's own stimulus
   always @(posedge clk) begin
      if (!rst_n)       tick_cnt <= 0;
      else if (tick_en) tick_cnt <= tick_cnt + 1;
   end

   // stimulus: tick every en_div clocks, serial strobe every 8 ticks
   always @(negedge clk) begin
      cyc = cyc + 1;
      tick_en  = ((cyc % en_div) == 0);
      sclk_stb = tick_en && (((tick_cnt + 1) % 8) == 0);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: stamps and per-event checks (R4, R5)
   always @(negedge clk) begin
      if (rst_n) begin
         if (fs_out && !fs_prev) begin
            fs_n++;
            fs_stamp = tick_cnt;
            fs_cyc = cyc;
         end
         if (!fs_out && fs_prev)
            chk((tick_cnt - fs_stamp) == 8, "R4 width", tick_cnt - fs_stamp, 8);
         if (dac_ld) begin
            ld_n++;
            ld_stamp = tick_cnt;
            if (ld_prev) chk(1'b0, "R5 width", 2, 1);
         end
      end
      fs_prev = fs_out;
      ld_prev = dac_ld;
   end

   task automatic wait_fs();
      int n0;
      n0 = fs_n;
      while (fs_n == n0) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      adv_in = '0;
      repeat (5) @(negedge clk);
      chk(fs_out == 1'b0, "R1 fs in reset", int'(fs_out), 0);
      chk(dac_ld == 1'b0, "R1 ld in reset", int'(dac_ld), 0);
      fs_n = 0; ld_n = 0;
      rst_n = 1'b1;
   endtask

   task automatic t_first();
      wait_fs();
      chk(fs_stamp == 280, "R2 first frame", fs_stamp, 280);
      chk(ld_stamp == 272, "R6 default load", ld_stamp, 272);
      chk(ld_n == 1, "R5 one load before first frame", ld_n, 1);
   endtask

   // called right after a frame rise; sets advance, checks next interval
   task automatic run_interval(input int a_set, input int a_exp, input string req);
      int f0, l0;
      f0 = fs_stamp;
      l0 = ld_n;
      adv_in = 5'(a_set);
      wait_fs();
      chk((fs_stamp - f0) == 2048, "R3 period", fs_stamp - f0, 2048);
      chk((ld_n - l0) == 1, "R5 one load per interval", ld_n - l0, 1);
      chk((fs_stamp - ld_stamp) == 8 + 8 * a_exp, req, fs_stamp - ld_stamp, 8 + 8 * a_exp);
   endtask

   task automatic t_mid_change();
      int start;
      start = fs_stamp - 280 + 2048;
      while (tick_cnt < start + 4) @(negedge clk);
      adv_in = 5'd0;
      wait_fs();
      chk((fs_stamp - ld_stamp) == 168, "R9 mid-interval change deferred", fs_stamp - ld_stamp, 168);
      run_interval(0, 0, "R9 change applied next interval");
   endtask

   task automatic t_slow_ticks();
      int c0;
      en_div = 3;
      run_interval(5, 5, "R10 slow ticks offset");
      c0 = fs_cyc;
      run_interval(5, 5, "R10 slow ticks offset");
      chk((fs_cyc - c0) == 6144, "R10 period in clocks", fs_cyc - c0, 6144);
      en_div = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_first();
      run_interval(0, 0, "R6 default load");
      run_interval(31, 31, "R7 max advance");
      run_interval(1, 1, "R7 single step");
      dac_on = 1'b1;
      run_interval(20, 1, "R8 ignored while on");
      run_interval(20, 1, "R8 ignored while on");
      dac_on = 1'b0;
      run_interval(20, 20, "R8 taken while off");
      t_mid_change();
      t_slow_ticks();
      t_reset();
      t_first();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule